// File: doc/BRIEF.md
# Mode-Selectable Pipelined Magnitude Comparator

This block compares two unsigned operands of equal, parameterised width and presents a registered two-bit verdict. A build-time mode parameter fixes the function. In three-way mode the block tells whether the first operand is above, below or equal to the second. In the two threshold modes it raises a single condition, at-least or at-most, and copies it onto both result bits so that a consumer can read either bit.

An optional stage of operand registers ahead of the comparison trades one cycle of latency for a shorter path from the operand pins to the result register. With that stage present, the operands reach the result in two enabled clock cycles. Without it they take one. A clock enable freezes the whole pipeline, and a synchronous reset clears it. The logic is plain fabric, with no arithmetic primitives and no device selection.

Top module: `magcmp`

## Requirements
- R1: In three-way mode (MODE = CMP_THREE_WAY) the result is 2'b01 when op_a > op_b, 2'b10 when op_b > op_a, and 2'b00 when they are equal.
- R2: In at-least mode (MODE = CMP_AT_LEAST, the default) the result is 2'b11 when op_a >= op_b and 2'b00 otherwise.
- R3: In at-most mode (MODE = CMP_AT_MOST) the result is 2'b11 when op_a <= op_b and 2'b00 otherwise.
- R4: With IN_REG = 1 (the default), operands sampled at an enabled clock edge set the result after the second enabled edge.
- R5: With IN_REG = 0, operands sampled at an enabled clock edge set the result after that same edge.
- R6: A clock edge with rst high clears every pipeline register, whatever en is. The result then reads 2'b00, and stored operands read as zero.
- R7: At a clock edge with en low and rst low, no pipeline register changes. The result holds, and latency counts enabled edges only.
- R8: Operands are compared as unsigned binary numbers, so an operand with its top bit set is larger than any operand with that bit clear.
- R9: The code 2'b11 never appears in three-way mode, and the codes 2'b01 and 2'b10 never appear in the threshold modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, takes priority over en |
| en | input | 1 | Clock enable for all pipeline registers |
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| res | output | 2 | Registered comparison result, encoded per MODE |

## Verification
The hardest situation to reach is a stall or a reset landing while operands are part-way through the two-stage pipeline. The operand registers then hold a pair that the result has not yet reflected, and the block must neither lose that pair nor pass it on early. The bench reaches this by toggling en and pulsing rst in the middle of streams whose operands change every cycle. It runs six copies of the block, covering every mode at both latencies, against one behavioural model, so a stage that is skipped or advanced wrongly shows up as a wrong code on the next compare.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

   // Function selected at build time
   typedef enum logic [1:0] {
      CMP_THREE_WAY = 2'd0,
      CMP_AT_LEAST  = 2'd1,
      CMP_AT_MOST   = 2'd2
   } cmp_mode_e;

   localparam int unsigned RES_W = 2;

   // Three-way codes
   localparam logic [RES_W-1:0] CODE_EQ   = 2'b00;
   localparam logic [RES_W-1:0] CODE_A_GT = 2'b01;
   localparam logic [RES_W-1:0] CODE_B_GT = 2'b10;
   // Threshold codes
   localparam logic [RES_W-1:0] CODE_TRUE  = 2'b11;
   localparam logic [RES_W-1:0] CODE_FALSE = 2'b00;

   // Raw relation between the operands, produced by the comparison core
   typedef struct packed {
      logic a_gt;
      logic a_eq;
   } cmp_rel_t;

endpackage

// File: rtl/mcmp_in_stage.sv
module mcmp_in_stage #(
   parameter int unsigned WIDTH   = 25,
   parameter bit          USE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] b_out
);

   generate
      if (USE_REG) begin : g_reg
         logic [WIDTH-1:0] a_q;
         logic [WIDTH-1:0] b_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               a_q <= '0;
               b_q <= '0;
            end else if (en) begin
               a_q <= a_in;
               b_q <= b_in;
            end
         end

         assign a_out = a_q;
         assign b_out = b_q;

         // stored operands must not move while the pipeline is stalled
         AST_OPS_HELD: assert property (@(posedge clk) disable iff (rst)
            !$past(en) && !$past(rst) |-> $stable(a_q) && $stable(b_q)); // R7
      end else begin : g_pass
         assign a_out = a_in;
         assign b_out = b_in;
      end
   endgenerate

endmodule

// File: rtl/mcmp_core.sv
module mcmp_core #(
   parameter int unsigned WIDTH = 25
) (
   input  logic [WIDTH-1:0]         a,
   input  logic [WIDTH-1:0]         b,
   output mcmp_pkg::cmp_rel_t       rel
);

   // Unsigned magnitude relation; both operands are zero-extended by type
   always_comb begin
      rel.a_gt = (a > b);
      rel.a_eq = (a == b);
   end

endmodule

// File: rtl/mcmp_encode.sv
module mcmp_encode #(
   parameter mcmp_pkg::cmp_mode_e MODE = mcmp_pkg::CMP_AT_LEAST
) (
   input  mcmp_pkg::cmp_rel_t                  rel,
   output logic [mcmp_pkg::RES_W-1:0]          code
);
   import mcmp_pkg::*;

   generate
      if (MODE == CMP_THREE_WAY) begin : g_three
         always_comb begin
            if (rel.a_eq)      code = CODE_EQ;
            else if (rel.a_gt) code = CODE_A_GT;
            else               code = CODE_B_GT;
         end
      end else if (MODE == CMP_AT_LEAST) begin : g_least
         logic hit;
         assign hit  = rel.a_gt | rel.a_eq;
         assign code = {RES_W{hit}};
      end else begin : g_most
         logic hit;
         assign hit  = ~rel.a_gt;
         assign code = {RES_W{hit}};
      end
   endgenerate

endmodule

// File: rtl/mcmp_out_reg.sv
module mcmp_out_reg #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= d;
   end

   // set by the first reset; lets the checks ignore pre-reset values
   logic armed;
   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b1;
   end

   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(armed) && $past(rst) |-> q == '0); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(armed) && !$past(en) && !$past(rst) |-> $stable(q)); // R7

endmodule

// File: rtl/magcmp.sv
module magcmp #(
   parameter int unsigned         WIDTH  = 25,
   parameter bit                  IN_REG = 1'b1,
   parameter mcmp_pkg::cmp_mode_e MODE   = mcmp_pkg::CMP_AT_LEAST
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [1:0]       res
);
   import mcmp_pkg::*;

   localparam int unsigned     LATENCY = IN_REG ? 2 : 1;
   localparam logic [RES_W-1:0] EQ_CODE = (MODE == CMP_THREE_WAY) ? CODE_EQ : CODE_TRUE;

   // elaboration-time parameter checks
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("magcmp: WIDTH must be at least 1");
      end
      if (MODE != CMP_THREE_WAY && MODE != CMP_AT_LEAST && MODE != CMP_AT_MOST) begin : g_bad_mode
         $error("magcmp: unsupported MODE");
      end
      if (LATENCY != 1 && LATENCY != 2) begin : g_bad_lat
         $error("magcmp: latency out of range");
      end
   endgenerate

   logic [WIDTH-1:0] a_s;
   logic [WIDTH-1:0] b_s;
   cmp_rel_t         rel;
   logic [RES_W-1:0] code;

   mcmp_in_stage #(.WIDTH(WIDTH), .USE_REG(IN_REG)) u_in (
      .clk(clk), .rst(rst), .en(en),
      .a_in(op_a), .b_in(op_b),
      .a_out(a_s), .b_out(b_s)
   );

   mcmp_core #(.WIDTH(WIDTH)) u_core (
      .a(a_s), .b(b_s), .rel(rel)
   );

   mcmp_encode #(.MODE(MODE)) u_enc (
      .rel(rel), .code(code)
   );

   mcmp_out_reg #(.W(RES_W)) u_out (
      .clk(clk), .rst(rst), .en(en), .d(code), .q(res)
   );

   // ---------------- checks on the port behaviour ----------------
   logic seen_rst;
   always_ff @(posedge clk) begin
      if (rst) seen_rst <= 1'b1;
   end

   generate
      if (MODE == CMP_THREE_WAY) begin : g_chk_three
         AST_NO_BOTH_SET: assert property (@(posedge clk) disable iff (rst)
            seen_rst |-> res != 2'b11); // R9
      end else begin : g_chk_thresh
         AST_BITS_MATCH: assert property (@(posedge clk) disable iff (rst)
            seen_rst |-> res[1] == res[0]); // R9
      end

      if (IN_REG) begin : g_chk_lat2
         AST_EQUAL_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
            $past(seen_rst, 2) && $past(en, 1) && $past(en, 2) &&
            !$past(rst, 1) && !$past(rst, 2) &&
            ($past(op_a, 2) == $past(op_b, 2)) |-> res == EQ_CODE); // R4
      end else begin : g_chk_lat1
         AST_EQUAL_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
            $past(seen_rst) && $past(en) && !$past(rst) &&
            ($past(op_a) == $past(op_b)) |-> res == EQ_CODE); // R5
      end
   endgenerate

endmodule

// File: tb/test_magcmp.sv
module test_magcmp;
   import mcmp_pkg::*;

   localparam int W = 25;
   localparam int N = 6;
   // configuration table: mode (0 three-way, 1 at-least, 2 at-most), latency
   localparam int MODE_OF [N] = '{1, 1, 0, 0, 2, 2};
   localparam int LAT_OF  [N] = '{2, 1, 2, 1, 2, 1};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] a   = '0;
   logic [W-1:0] b   = '0;
   logic [1:0]   r [N];

   always #4 clk = ~clk;   // 125 MHz

   magcmp i_magcmp (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[0]));
   magcmp #(.WIDTH(W), .IN_REG(1'b0), .MODE(CMP_AT_LEAST)) i_ge_l1
      (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[1]));
   magcmp #(.WIDTH(W), .IN_REG(1'b1), .MODE(CMP_THREE_WAY)) i_tw_l2
      (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[2]));
   magcmp #(.WIDTH(W), .IN_REG(1'b0), .MODE(CMP_THREE_WAY)) i_tw_l1
      (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[3]));
   magcmp #(.WIDTH(W), .IN_REG(1'b1), .MODE(CMP_AT_MOST)) i_le_l2
      (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[4]));
   magcmp #(.WIDTH(W), .IN_REG(1'b0), .MODE(CMP_AT_MOST)) i_le_l1
      (.clk(clk), .rst(rst), .en(en), .op_a(a), .op_b(b), .res(r[5]));

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string phase  = "R6";

   // behavioural model: pending operand queue per copy plus visible result
   longint unsigned qa [N][$];
   longint unsigned qb [N][$];
   logic [1:0]      exp_r [N];

   function automatic logic [1:0] want(int m, longint unsigned x, longint unsigned y);
      case (m)
         0:       return (x > y) ? 2'b01 : ((x < y) ? 2'b10 : 2'b00);   // R1
         1:       return (x >= y) ? 2'b11 : 2'b00;                      // R2
         default: return (x <= y) ? 2'b11 : 2'b00;                      // R3
      endcase
   endfunction

   function automatic string mode_tag(int k);
      case (MODE_OF[k])
         0:       return "R1";
         1:       return "R2";
         default: return "R3";
      endcase
   endfunction

   // predict the state after the coming edge from the inputs now applied
   task automatic model_step();
      for (int k = 0; k < N; k++) begin
         if (rst) begin
            exp_r[k] = 2'b00;
            qa[k].delete();
            qb[k].delete();
            for (int s = 1; s < LAT_OF[k]; s++) begin
               qa[k].push_back(0);
               qb[k].push_back(0);
            end
         end else if (en) begin
            qa[k].push_back(longint'(a));
            qb[k].push_back(longint'(b));
            exp_r[k] = want(MODE_OF[k], qa[k].pop_front(), qb[k].pop_front());
         end
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < N; k++) begin
         checks++;
         if (r[k] !== exp_r[k]) begin
            fails++;
            $display("FAIL %s/%s copy %0d (lat %0d): res=%b expected %b",
                     phase, mode_tag(k), k, LAT_OF[k], r[k], exp_r[k]);
         end
         checks++;
         if ((MODE_OF[k] == 0 && r[k] === 2'b11) ||
             (MODE_OF[k] != 0 && (r[k] === 2'b01 || r[k] === 2'b10))) begin
            fails++;
            $display("FAIL R9 copy %0d: res=%b expected a legal code for its mode", k, r[k]);
         end
      end
   endtask

   task automatic cyc(input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic env, input logic rstv);
      a = av; b = bv; en = env; rst = rstv;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   function automatic logic [W-1:0] rnd();
      return W'($urandom);
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
   end

   initial begin
      for (int k = 0; k < N; k++) exp_r[k] = 2'b00;
      // R6: reset state
      phase = "R6";
      cyc('0, '0, 1'b0, 1'b1);
      cyc(25'd7, 25'd3, 1'b1, 1'b1);

      // R1 R2 R3: directed relations, small values
      phase = "R1 R2 R3";
      cyc(25'd5, 25'd3, 1'b1, 1'b0);
      cyc(25'd3, 25'd5, 1'b1, 1'b0);
      cyc(25'd9, 25'd9, 1'b1, 1'b0);
      cyc(25'd0, 25'd1, 1'b1, 1'b0);
      cyc(25'd1, 25'd0, 1'b1, 1'b0);
      cyc(25'd0, 25'd0, 1'b1, 1'b0);
      cyc(25'd0, 25'd0, 1'b1, 1'b0);

      // R4 R5: relation flips every cycle so an off-by-one stage shows
      phase = "R4 R5";
      for (int i = 0; i < 20; i++) begin
         if (i % 3 == 0)      cyc(25'd100, 25'd50, 1'b1, 1'b0);
         else if (i % 3 == 1) cyc(25'd50, 25'd100, 1'b1, 1'b0);
         else                 cyc(25'd77, 25'd77, 1'b1, 1'b0);
      end

      // R8: top bit set against top bit clear
      phase = "R8";
      cyc({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 1'b1, 1'b0);
      cyc({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}}, 1'b1, 1'b0);
      cyc({W{1'b1}}, {W{1'b1}}, 1'b1, 1'b0);
      cyc({W{1'b1}}, '0, 1'b1, 1'b0);
      cyc('0, {W{1'b1}}, 1'b1, 1'b0);
      cyc(25'd1, 25'd1, 1'b1, 1'b0);

      // R7: stalls with changing operands, including mid-pipeline
      phase = "R7";
      cyc(25'd10, 25'd20, 1'b1, 1'b0);
      cyc(25'd30, 25'd20, 1'b0, 1'b0);
      cyc(25'd5, 25'd5, 1'b0, 1'b0);
      cyc(25'd40, 25'd1, 1'b1, 1'b0);
      cyc(25'd2, 25'd90, 1'b0, 1'b0);
      cyc(25'd3, 25'd3, 1'b1, 1'b0);
      for (int i = 0; i < 200; i++)
         cyc(rnd(), rnd(), 1'($urandom % 2), 1'b0);

      // R6: reset in mid-stream, with en low and with en high
      phase = "R6";
      cyc(25'd8, 25'd4, 1'b1, 1'b0);
      cyc(25'd4, 25'd8, 1'b0, 1'b1);
      cyc(25'd6, 25'd2, 1'b0, 1'b0);
      cyc(25'd6, 25'd2, 1'b1, 1'b0);
      cyc(25'd2, 25'd6, 1'b1, 1'b1);
      cyc(25'd2, 25'd6, 1'b1, 1'b0);
      cyc(25'd2, 25'd6, 1'b1, 1'b0);

      // R1 R2 R3: long random run with occasional equal operands,
      // stalls and resets
      phase = "R1 R2 R3";
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] x, y;
         x = rnd();
         y = (i % 5 == 0) ? x : ((i % 7 == 0) ? x + 1'b1 : rnd());
         cyc(x, y, 1'($urandom % 4 != 0), 1'($urandom % 97 == 0));
      end

      summary();
   end

endmodule